// File: doc/BRIEF.md
# Serial Configuration Stream Loader

After reset, system software or a sequencer pulses `start`, and this block walks a byte stream held in a serial configuration memory. It fetches one byte at a time through a request/valid handshake with a memory reader, which handles the serial wire protocol. It then checks a four-byte header. The first header byte marks a programmed memory. The second is a fixed zero. The last two give the payload size. Each six-byte record that follows becomes one write on an internal register bus.

The payload is a plain little-endian concatenation of records, with no padding, so records fall across 32-bit word boundaries freely. Each record starts with a 16-bit address field. Its low bits name a dword register and its high bits name a port. A 32-bit data word follows the address field. One particular address field, the debug control register, may only appear as the first record. A memory whose first byte is wrong is treated as blank: nothing is loaded, and the block reports the memory as absent without raising an error. When loading ends, a sticky done flag rises, along with an error flag if the stream was malformed. Both flags stay until the next accepted `start`.

Top module: `cfg_stream_loader`

## Requirements
- R1: If stream byte 0 is not 0x5A, no write strobe occurs, `mem_present` stays 0, `load_error` stays 0 and `load_done` rises one cycle after that byte is accepted; if byte 0 is 0x5A, `mem_present` rises one cycle after it is accepted.
- R2: If stream byte 1 is not 0x00, `load_error` and `load_done` rise one cycle after that byte is accepted and no write strobe occurs.
- R3: The payload length is byte 2 plus 256 times byte 3. Bytes are requested at addresses 0, 1, 2, … in order, no address past 3 + length is requested, and exactly length/6 write strobes occur for a well-formed stream.
- R4: A record at payload offset 6k holds the address field in its first two bytes and the data word in the next four, each least significant byte first; the strobe carries `wr_index` = field[9:0], `wr_port` = field[15:10] and `wr_data` = the data word, and it rises one cycle after the record's sixth byte is accepted.
- R5: A length that is not a multiple of 6 raises `load_error` and `load_done` one cycle after byte 3 is accepted, with no write strobe.
- R6: A record whose address field equals 0x0077 is written normally when it is the first record. Anywhere else it produces no strobe, and `load_error` and `load_done` rise one cycle after its sixth byte is accepted, with no further fetches.
- R7: `load_done` rises exactly one cycle after the last record's strobe, or one cycle after byte 3 is accepted when the length is zero.
- R8: `wr_en` is a single-cycle pulse.
- R9: `start` is ignored while loading is in progress. `load_done`, `load_error` and `mem_present` hold their values until an accepted `start` clears them.
- R10: After reset, `fetch_req`, `wr_en`, `load_done`, `load_error` and `mem_present` are all 0.
- R11: `fetch_req` stays high with `fetch_addr` unchanged until `fetch_valid` is seen; a byte is taken only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| fetch_req | output | 1 | Byte request to the memory reader |
| fetch_addr | output | FETCH_AW | Byte address being requested |
| fetch_data | input | 8 | Byte returned by the memory reader |
| fetch_valid | input | 1 | `fetch_data` is valid for the current request |
| wr_en | output | 1 | Register write strobe |
| wr_index | output | IDX_W | Dword register index |
| wr_port | output | 16-IDX_W | Port number |
| wr_data | output | 32 | Register write data |
| load_done | output | 1 | Loading finished (sticky) |
| load_error | output | 1 | Stream malformed (sticky) |
| mem_present | output | 1 | Signature byte found |

## Verification
The hardest situation to reach from the ports is the last record completing while the memory reader answers slowly and a new `start` arrives in the middle of the load. This is where the one-cycle gap between the final strobe and `load_done` meets the rule that `start` is ignored while busy. The stimulus replays a three-record image whose records straddle dword boundaries. The reader's response latency is varied between zero and three cycles, and a start pulse is injected mid-stream. A behavioural model is compared against every output on every clock, so an extra fetch, a late done or a misplaced field shows up in the exact cycle it happens.

// File: rtl/cfgl_pkg.sv
// Shared constants and types for the configuration stream loader.
// Assumes a byte-addressed stream with a 4-byte header and 6-byte records.
package cfgl_pkg;
    localparam logic [7:0] STREAM_SIG = 8'h5A;
    localparam int HDR_BYTES = 4;
    localparam int REC_BYTES = 6;
    localparam int FIELD_W   = 16;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RUN  = 2'd1,
        LD_LAST = 2'd2
    } ld_state_t;
endpackage

// File: rtl/cfgl_fetch.sv
// Byte-fetch requester: holds a request and its address until the memory
// reader answers with valid. Assumes the reader drives valid only while
// a request is pending.
module cfgl_fetch #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic          fetch_valid,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    output logic          byte_stb
);
    // A byte is taken only when a request is open and the reader answers.
    assign byte_stb = fetch_req & fetch_valid;

    // Open a new request on issue, close it once the byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
        end else if (issue) begin
            fetch_req  <= 1'b1;
            fetch_addr <= issue_addr;
        end else if (byte_stb) begin
            fetch_req  <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgl_rec_asm.sv
// Record assembler: keeps the last five payload bytes so that, together with
// the byte arriving now, a whole little-endian record is visible at once.
// Assumes shift_en pulses exactly once per payload byte.
module cfgl_rec_asm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        shift_en,
    input  logic [7:0]  byte_in,
    output logic [15:0] rec_field,
    output logic [31:0] rec_data
);
    localparam int HOLD_W = (cfgl_pkg::REC_BYTES - 1) * 8;

    logic [HOLD_W-1:0] hold;
    logic [HOLD_W+7:0] full;

    // Newest byte enters at the top so the oldest ends in the low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (shift_en) begin
            hold <= {byte_in, hold[HOLD_W-1:8]};
        end
    end

    // The live byte completes the record: field in bytes 0..1, data in 2..5.
    assign full      = {byte_in, hold};
    assign rec_field = full[15:0];
    assign rec_data  = full[47:16];
endmodule

// File: rtl/cfg_stream_loader.sv
// Configuration stream loader: fetches a header and packed 6-byte records
// from a serial memory reader and issues one register write per record.
// Assumes FETCH_AW >= 17 so that 3 + any 16-bit length is addressable, and
// that start is only acted on while idle.
module cfg_stream_loader #(
    parameter int          FETCH_AW  = 24,
    parameter int          IDX_W     = 10,
    parameter logic [15:0] DBG_FIELD = 16'h0077,
    localparam int         PORT_W    = 16 - IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                fetch_req,
    output logic [FETCH_AW-1:0] fetch_addr,
    input  logic [7:0]          fetch_data,
    input  logic                fetch_valid,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_index,
    output logic [PORT_W-1:0]   wr_port,
    output logic [31:0]         wr_data,
    output logic                load_done,
    output logic                load_error,
    output logic                mem_present
);
    import cfgl_pkg::*;

    localparam logic [2:0] REC_LAST = 3'(REC_BYTES - 1);

    ld_state_t           state;
    logic                byte_stb;
    logic                issue;
    logic [FETCH_AW-1:0] issue_addr;
    logic [7:0]          len_lo;
    logic [15:0]         pay_len;
    logic [15:0]         len_now;
    logic [2:0]          rec_pos;
    logic                rec_seen;
    logic                is_hdr;
    logic                is_last;
    logic                shift_en;
    logic [15:0]         rec_field;
    logic [31:0]         rec_data;
    logic                fin, fin_err, go_last, fire, set_pres, cont;

    cfgl_fetch #(.AW(FETCH_AW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue),
        .issue_addr (issue_addr),
        .fetch_valid(fetch_valid),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .byte_stb   (byte_stb)
    );

    cfgl_rec_asm u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .byte_in  (fetch_data),
        .rec_field(rec_field),
        .rec_data (rec_data)
    );

    // Position of the byte being taken within header and stream.
    assign is_hdr   = fetch_addr < FETCH_AW'(HDR_BYTES);
    assign is_last  = fetch_addr == (FETCH_AW'(pay_len) + FETCH_AW'(HDR_BYTES - 1));
    assign len_now  = {fetch_data, len_lo};
    assign shift_en = (state == LD_RUN) && byte_stb && !is_hdr;

    // Decide, for the byte being taken, whether to continue, write or stop.
    always_comb begin
        fin      = 1'b0;
        fin_err  = 1'b0;
        go_last  = 1'b0;
        fire     = 1'b0;
        set_pres = 1'b0;
        cont     = 1'b0;
        if (state == LD_RUN && byte_stb) begin
            if (is_hdr) begin
                case (fetch_addr[1:0])
                    2'd0: begin
                        if (fetch_data == STREAM_SIG) begin
                            set_pres = 1'b1;
                            cont     = 1'b1;
                        end else begin
                            fin = 1'b1;
                        end
                    end
                    2'd1: begin
                        if (fetch_data == 8'h00) begin
                            cont = 1'b1;
                        end else begin
                            fin     = 1'b1;
                            fin_err = 1'b1;
                        end
                    end
                    2'd2: cont = 1'b1;
                    default: begin
                        if ((len_now % 16'd6) != 16'd0) begin
                            fin     = 1'b1;
                            fin_err = 1'b1;
                        end else if (len_now == 16'd0) begin
                            fin = 1'b1;
                        end else begin
                            cont = 1'b1;
                        end
                    end
                endcase
            end else if (rec_pos != REC_LAST) begin
                cont = 1'b1;
            end else if (rec_field == DBG_FIELD && rec_seen) begin
                fin     = 1'b1;
                fin_err = 1'b1;
            end else begin
                fire = 1'b1;
                if (is_last) begin
                    go_last = 1'b1;
                end else begin
                    cont = 1'b1;
                end
            end
        end
    end

    // Request the first byte on start, the next byte whenever parsing goes on.
    always_comb begin
        issue      = cont || (state == LD_IDLE && start);
        issue_addr = (state == LD_IDLE) ? '0 : fetch_addr + FETCH_AW'(1);
    end

    // Sequencing, header capture, record counting and register-bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= LD_IDLE;
            load_done   <= 1'b0;
            load_error  <= 1'b0;
            mem_present <= 1'b0;
            wr_en       <= 1'b0;
            wr_index    <= '0;
            wr_port     <= '0;
            wr_data     <= '0;
            len_lo      <= '0;
            pay_len     <= '0;
            rec_pos     <= '0;
            rec_seen    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            case (state)
                LD_IDLE: begin
                    if (start) begin
                        state       <= LD_RUN;
                        load_done   <= 1'b0;
                        load_error  <= 1'b0;
                        mem_present <= 1'b0;
                        rec_pos     <= '0;
                        rec_seen    <= 1'b0;
                    end
                end
                LD_RUN: begin
                    if (set_pres) begin
                        mem_present <= 1'b1;
                    end
                    if (byte_stb && is_hdr && fetch_addr[1:0] == 2'd2) begin
                        len_lo <= fetch_data;
                    end
                    if (byte_stb && is_hdr && fetch_addr[1:0] == 2'd3) begin
                        pay_len <= len_now;
                    end
                    if (shift_en) begin
                        rec_pos <= (rec_pos == REC_LAST) ? '0 : rec_pos + 3'd1;
                    end
                    if (fire) begin
                        wr_en    <= 1'b1;
                        wr_index <= rec_field[IDX_W-1:0];
                        wr_port  <= rec_field[15:IDX_W];
                        wr_data  <= rec_data;
                        rec_seen <= 1'b1;
                    end
                    if (fin) begin
                        load_done  <= 1'b1;
                        load_error <= fin_err;
                        state      <= LD_IDLE;
                    end else if (go_last) begin
                        state <= LD_LAST;
                    end
                end
                default: begin
                    load_done <= 1'b1;
                    state     <= LD_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/cfgl_checker.sv
// Protocol checker for the configuration stream loader, bound to the top.
// Counts writes since the last accepted start to police the debug record.
module cfgl_checker #(
    parameter int          FETCH_AW  = 24,
    parameter int          IDX_W     = 10,
    parameter logic [15:0] DBG_FIELD = 16'h0077
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                fetch_req,
    input logic [FETCH_AW-1:0] fetch_addr,
    input logic                fetch_valid,
    input logic                wr_en,
    input logic [IDX_W-1:0]    wr_index,
    input logic [15-IDX_W:0]   wr_port,
    input logic                load_done,
    input logic                load_error,
    input logic                mem_present
);
    logic [15:0] wr_cnt;

    // Writes seen since the loader last left idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (start && !fetch_req && !wr_en) begin
            wr_cnt <= '0;
        end else if (wr_en && wr_cnt != 16'hFFFF) begin
            wr_cnt <= wr_cnt + 16'd1;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_valid |=> fetch_req && $stable(fetch_addr)); // R11
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R8
    AST_WR_NEEDS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mem_present); // R1
    AST_ERR_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_error |-> load_done); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !fetch_req && !wr_en); // R7
    AST_DBG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && {wr_port, wr_index} == DBG_FIELD |-> wr_cnt == 16'd0); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done && !start |=> load_done); // R9
endmodule

bind cfg_stream_loader cfgl_checker #(
    .FETCH_AW (FETCH_AW),
    .IDX_W    (IDX_W),
    .DBG_FIELD(DBG_FIELD)
) u_cfgl_chk (.*);

// File: tb/tb_cfg_stream_loader.sv
// Bench: behavioural model advanced once per cycle, compared on every clock.
module tb_cfg_stream_loader;
    localparam int AW = 24;
    localparam int IW = 10;
    localparam int PW = 16 - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    fetch_data = 8'h00;
    logic          fetch_valid = 1'b0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          wr_en;
    logic [IW-1:0] wr_index;
    logic [PW-1:0] wr_port;
    logic [31:0]   wr_data;
    logic          load_done, load_error, mem_present;

    always #5 clk = ~clk;

    cfg_stream_loader #(.FETCH_AW(AW), .IDX_W(IW)) dut (.*);

    logic [7:0] mem [0:255];
    int  lat = 0;
    int  checks = 0, errors = 0;
    bit  finished = 0, start_pend = 0, rst_hold = 1;
    bit  r_busy = 0;
    int  r_cnt = 0;
    int  wr_seen = 0;
    logic [15:0] last_field;
    logic [31:0] last_data;

    // model state
    bit m_busy, m_req, m_done, m_err, m_pres, m_wr, m_last;
    int m_addr, m_len, m_lenlo, m_nrec;
    logic [15:0] m_field;
    logic [31:0] m_data;
    logic [7:0] m_q[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] rd(input logic [AW-1:0] a);
        return (a < 256) ? mem[a[7:0]] : 8'hFF;
    endfunction

    task automatic model_reset();
        m_busy = 0; m_req = 0; m_done = 0; m_err = 0; m_pres = 0;
        m_wr = 0; m_last = 0; m_addr = 0; m_len = 0; m_lenlo = 0; m_nrec = 0;
        m_q.delete();
    endtask

    task automatic model_stop(input bit err);
        m_done = 1; m_err = err; m_req = 0; m_busy = 0;
    endtask

    task automatic model_byte(input logic [7:0] d);
        bit go;
        go = 1;
        if (m_addr == 0) begin
            if (d != 8'h5A) begin model_stop(0); go = 0; end
            else m_pres = 1;
        end else if (m_addr == 1) begin
            if (d != 8'h00) begin model_stop(1); go = 0; end
        end else if (m_addr == 2) begin
            m_lenlo = d;
        end else if (m_addr == 3) begin
            m_len = d * 256 + m_lenlo;
            if (m_len % 6 != 0) begin model_stop(1); go = 0; end
            else if (m_len == 0) begin model_stop(0); go = 0; end
        end else begin
            m_q.push_back(d);
            if (m_q.size() == 6) begin
                m_field = {m_q[1], m_q[0]};
                m_data  = {m_q[5], m_q[4], m_q[3], m_q[2]};
                m_q.delete();
                if (m_field == 16'h0077 && m_nrec > 0) begin
                    model_stop(1); go = 0;
                end else begin
                    m_wr = 1; m_nrec++;
                    if (m_addr == m_len + 3) begin
                        m_last = 1; m_req = 0; go = 0;
                    end
                end
            end
        end
        if (go) m_addr++;
    endtask

    // Per-cycle engine: compare, drive inputs, advance the model.
    initial begin
        model_reset();
        forever begin
            @(negedge clk);
            chk("R7 load_done", load_done, m_done);
            chk("R5 load_error", load_error, m_err);
            chk("R1 mem_present", mem_present, m_pres);
            chk("R8 wr_en", wr_en, m_wr);
            chk("R11 fetch_req", fetch_req, m_req);
            if (m_req) chk("R3 fetch_addr", fetch_addr, m_addr);
            if (m_wr) begin
                chk("R4 wr_index", wr_index, m_field[IW-1:0]);
                chk("R4 wr_port", wr_port, m_field[15:IW]);
                chk("R4 wr_data", wr_data, m_data);
            end
            if (wr_en) begin
                wr_seen++;
                last_field = {wr_port, wr_index};
                last_data  = wr_data;
            end
            rst_n = !rst_hold;
            start = start_pend;
            start_pend = 0;
            if (fetch_valid) begin fetch_valid = 0; r_busy = 0; end
            if (!rst_n) begin
                r_busy = 0;
            end else begin
                if (fetch_req && !r_busy) begin r_busy = 1; r_cnt = lat; end
                if (r_busy) begin
                    if (r_cnt == 0) begin fetch_valid = 1; fetch_data = rd(fetch_addr); end
                    else r_cnt--;
                end
            end
            if (!rst_n) begin
                model_reset();
            end else begin
                m_wr = 0;
                if (m_last) begin
                    m_last = 0; m_done = 1; m_busy = 0;
                end else if (!m_busy) begin
                    if (start) begin
                        m_done = 0; m_err = 0; m_pres = 0; m_busy = 1;
                        m_req = 1; m_addr = 0; m_nrec = 0; m_q.delete();
                    end
                end else if (fetch_valid && m_req) begin
                    model_byte(fetch_data);
                end
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    endtask

    task automatic put_hdr(input int len);
        mem[0] = 8'h5A; mem[1] = 8'h00;
        mem[2] = len[7:0]; mem[3] = len[15:8];
    endtask

    task automatic put_rec(input int n, input logic [15:0] f, input logic [31:0] d);
        int b;
        b = 4 + 6 * n;
        mem[b] = f[7:0];   mem[b+1] = f[15:8];
        mem[b+2] = d[7:0]; mem[b+3] = d[15:8];
        mem[b+4] = d[23:16]; mem[b+5] = d[31:24];
    endtask

    task automatic run(input int mid_start_after);
        wr_seen = 0;
        @(posedge clk);
        start_pend = 1;
        repeat (3) @(posedge clk);
        if (mid_start_after > 0) begin
            repeat (mid_start_after) @(posedge clk);
            start_pend = 1;
        end
        for (int i = 0; i < 5000 && !(m_done && !m_busy); i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic load_good();
        clear_mem();
        put_hdr(18);
        put_rec(0, 16'h0077, 32'h010D_0077);
        put_rec(1, 16'h0DF5, 32'hDEAD_BEEF);
        put_rec(2, 16'hFFFF, 32'h1234_5678);
    endtask

    initial begin
        clear_mem();
        rst_hold = 1;
        repeat (4) @(posedge clk);
        // R10: reset state
        @(negedge clk);
        chk("R10 fetch_req", fetch_req, 0);
        chk("R10 wr_en", wr_en, 0);
        chk("R10 load_done", load_done, 0);
        chk("R10 load_error", load_error, 0);
        chk("R10 mem_present", mem_present, 0);
        rst_hold = 0;
        repeat (3) @(posedge clk);

        // R1: blank memory
        lat = 1; clear_mem(); mem[0] = 8'h00;
        run(0);
        chk("R1 writes", wr_seen, 0);
        chk("R1 present", mem_present, 0);
        chk("R1 error", load_error, 0);
        chk("R1 done", load_done, 1);

        // R3 R4 R6: three records, debug first, zero latency
        lat = 0; load_good();
        run(0);
        chk("R3 writes", wr_seen, 3);
        chk("R4 last field", last_field, 16'hFFFF);
        chk("R4 last data", last_data, 32'h1234_5678);
        chk("R6 first debug ok", load_error, 0);

        // R2: bad second header byte
        lat = 2; load_good(); mem[1] = 8'h01;
        run(0);
        chk("R2 writes", wr_seen, 0);
        chk("R2 error", load_error, 1);
        chk("R2 present", mem_present, 1);

        // R5: length not a multiple of 6
        lat = 1; load_good(); mem[2] = 8'd7;
        run(0);
        chk("R5 writes", wr_seen, 0);
        chk("R5 error", load_error, 1);

        // R7: zero length
        lat = 0; clear_mem(); put_hdr(0);
        run(0);
        chk("R7 writes", wr_seen, 0);
        chk("R7 done", load_done, 1);
        chk("R7 error", load_error, 0);

        // R6: debug record in second place
        lat = 1; clear_mem(); put_hdr(12);
        put_rec(0, 16'h0410, 32'hCAFE_0001);
        put_rec(1, 16'h0077, 32'h0000_0000);
        run(0);
        chk("R6 writes", wr_seen, 1);
        chk("R6 error", load_error, 1);

        // R9 R11: slow reader, start pulsed mid-load
        lat = 3; load_good();
        run(20);
        chk("R9 writes", wr_seen, 3);
        chk("R9 error cleared", load_error, 0);
        repeat (5) @(posedge clk);
        chk("R9 done sticky", load_done, 1);
        chk("R11 idle req", fetch_req, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule